// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two phase signals of an incremental encoder into a 32-bit position count. It also takes an index pulse and an external capture strobe. All four inputs pass through a two-flop synchronizer. They then pass through a glitch filter that runs on a programmable sample tick. After filtering, the phase pair is decoded at one, two or four counts per encoder cycle.

The counter can wrap between two programmed bounds. It can be reloaded by the index pulse. Its value is latched into an index register on every index pulse, and into a capture register a programmed number of sample ticks after each capture strobe. A compare match, an illegal-transition detector, a direction tracker and a movement detector complete the event set.

Seven flags record these events. Each flag either holds until software clears it or follows its event. A masked OR of the flags drives one interrupt line. Configuration arrives as plain level inputs, and clearing a flag is a one-cycle pulse.

Top module: `qenc_counter`

## Requirements
- R1: After reset, `position`, `index_cnt`, `capture_cnt` and `flags` are zero, `dir_up` is 1 and `irq` is 0.
- R2: With `cfg_mode`=2 (code 3 behaves the same), every filtered edge of either phase counts. The forward order of `{a,b}` is 00→10→11→01→00 and counts up. The reverse order counts down.
- R3: With `cfg_mode`=1, only edges of phase A count, giving two counts per cycle. With `cfg_mode`=0, only a rising A counts: up when B is low, down when B is high.
- R4: `cfg_swap`=1 exchanges A and B before decoding, so the forward sequence counts down.
- R5: A new input level is accepted only after it has been seen on `cfg_filt`+1 consecutive sample ticks. A shorter pulse changes nothing.
- R6: Sample ticks occur once every 2^`cfg_pre` clock cycles.
- R7: With `cfg_wrap_en`=1, an up-count from `cfg_max` loads `cfg_init`, and a down-count from `cfg_init` loads `cfg_max`. Each such wrap sets flag bit 3.
- R8: A rising filtered index copies the count into `index_cnt` and sets flag bit 0. With `cfg_idx_rst`=1 it also loads `cfg_init` into the count.
- R9: A rising filtered capture strobe copies the count into `capture_cnt` after `cfg_cap_dly` sample ticks (at once when zero) and sets flag bit 4.
- R10: Flag bit 2 is set when the count changes to a value equal to `cfg_cmp`.
- R11: `dir_up` holds the direction of the last count (1 = up). Flag bit 5 is set when that direction reverses, and flag bit 6 is set on every count change.
- R12: When A and B change in the same filtered sample, flag bit 1 is set and the count does not change.
- R13: With `cfg_sticky`=1, flags hold until a 1 is pulsed on the matching `flag_clr` bit. With `cfg_sticky`=0, they follow their events for one cycle. `irq` is the OR of `flags & irq_en`. Bit order from bit 0 is: index, illegal, compare, wrap, capture, direction, move.
- R14: While `cfg_en`=0, the count, filters and delay hold their state and no flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Encoder phase A |
| enc_b | input | 1 | Encoder phase B |
| enc_idx | input | 1 | Encoder index pulse |
| enc_cap | input | 1 | External capture strobe |
| cfg_en | input | 1 | Block enable |
| cfg_mode | input | 2 | Resolution: 0 x1, 1 x2, 2/3 x4 |
| cfg_swap | input | 1 | Exchange A and B |
| cfg_filt | input | 2 | Filter length minus one, in samples |
| cfg_pre | input | 3 | Sample tick divider exponent |
| cfg_idx_rst | input | 1 | Index loads the initial value |
| cfg_wrap_en | input | 1 | Wrap between initial and maximum |
| cfg_sticky | input | 1 | Flags hold until cleared |
| cfg_max | input | 32 | Upper wrap bound |
| cfg_init | input | 32 | Initial / lower wrap bound |
| cfg_cmp | input | 32 | Compare value |
| cfg_cap_dly | input | 32 | Capture delay in sample ticks |
| irq_en | input | 7 | Per-flag interrupt enable |
| flag_clr | input | 7 | Write-one-to-clear pulse per flag |
| position | output | 32 | Current count |
| index_cnt | output | 32 | Count latched on index |
| capture_cnt | output | 32 | Count latched on capture |
| dir_up | output | 1 | Last count direction, 1 = up |
| flags | output | 7 | Event flags |
| irq | output | 1 | Interrupt request |

## Verification
The bench sends glitches that last one sample too few. It does this first at full rate and then behind a divide-by-8 tick. A filter that counts one sample short, or a prescaler that ticks too often, would let those glitches move the count. The bench also crosses both wrap bounds in both directions. An off-by-one bound check would either run past the maximum or skip the reload.

Several events are checked for their side effects. A simultaneous change on A and B must raise the illegal flag and leave the count untouched; a decoder that still counted would move the count. The capture value is sampled both before and after the programmed delay, which exposes a latch that fires at the strobe. Disabled stepping and the one-cycle, non-sticky flag mode are checked at the outputs. These checks show whether events leak through the enable or remain latched.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  localparam int unsigned NFLAG = 7;
  localparam int unsigned FB_IDX  = 0;
  localparam int unsigned FB_ERR  = 1;
  localparam int unsigned FB_CMP  = 2;
  localparam int unsigned FB_WRAP = 3;
  localparam int unsigned FB_CAP  = 4;
  localparam int unsigned FB_DIR  = 5;
  localparam int unsigned FB_MOVE = 6;

  typedef enum logic [1:0] {
    RES_X1  = 2'd0,
    RES_X2  = 2'd1,
    RES_X4  = 2'd2,
    RES_X4B = 2'd3
  } res_e;
endpackage

// File: rtl/qenc_tick.sv
module qenc_tick #(
  parameter int PSW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [PSW-1:0] pre,
  output logic           tick
);
  localparam int PW = (1 << PSW) - 1;

  logic [PW-1:0] cnt;
  logic [PW-1:0] mask;

  always_comb begin
    for (int i = 0; i < PW; i++) mask[i] = (32'(i) < 32'(pre));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (en) cnt <= cnt + 1'b1;
  end

  assign tick = en && ((cnt & mask) == mask);

  // R6
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pre != '0) |=> (!tick || pre != $past(pre)));
endmodule

// File: rtl/qenc_filter.sv
module qenc_filter #(
  parameter int LANES = 4,
  parameter int FW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [FW-1:0]    len,
  input  logic [LANES-1:0] raw,
  output logic [LANES-1:0] lvl
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic s1, s2, acc;
    logic [FW-1:0] run;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0; s2 <= 1'b0; acc <= 1'b0; run <= '0;
      end else begin
        s1 <= raw[g];
        s2 <= s1;
        if (tick) begin
          if (s2 == acc) run <= '0;
          else if (run == len) begin
            acc <= s2;
            run <= '0;
          end else run <= run + 1'b1;
        end
      end
    end

    assign lvl[g] = acc;

    // R5
    lvl_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl[g] != $past(lvl[g])) |-> $past(tick));
  end
endmodule

// File: rtl/qenc_core.sv
module qenc_core
  import qenc_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          a_in,
  input  logic          b_in,
  input  logic          idx_in,
  input  logic [1:0]    mode,
  input  logic          swap,
  input  logic          idx_rst,
  input  logic          wrap_en,
  input  logic [CW-1:0] cfg_max,
  input  logic [CW-1:0] cfg_init,
  input  logic [CW-1:0] cfg_cmp,
  output logic [CW-1:0] position,
  output logic [CW-1:0] index_cnt,
  output logic          dir_up,
  output logic          idx_ev,
  output logic          qerr_ev,
  output logic          cmp_ev,
  output logic          wrap_ev,
  output logic          dir_ev,
  output logic          move_ev
);
  // returns {wrapped, next value}
  function automatic logic [CW:0] next_pos(input logic [CW-1:0] p, input logic up,
                                           input logic wen, input logic [CW-1:0] hi,
                                           input logic [CW-1:0] lo);
    if (up) begin
      if (wen && p == hi) return {1'b1, lo};
      return {1'b0, p + 1'b1};
    end
    if (wen && p == lo) return {1'b1, hi};
    return {1'b0, p - 1'b1};
  endfunction

  logic a, b, a_d, b_d, idx_d;
  logic a_e, b_e, cnt_hit, cnt_up, step_ev, idx_load;
  logic [CW:0]   nx;
  logic [CW-1:0] pos_n;

  assign a   = swap ? b_in : a_in;
  assign b   = swap ? a_in : b_in;
  assign a_e = a ^ a_d;
  assign b_e = b ^ b_d;

  always_comb begin
    cnt_hit = 1'b0;
    cnt_up  = 1'b0;
    case (res_e'(mode))
      RES_X1: begin cnt_hit = a_e & a & ~b_e; cnt_up = ~b; end
      RES_X2: begin cnt_hit = a_e & ~b_e;     cnt_up = a ^ b; end
      default: begin
        cnt_hit = a_e ^ b_e;
        cnt_up  = a_e ? (a ^ b) : ~(a ^ b);
      end
    endcase
  end

  assign step_ev  = en & cnt_hit;
  assign qerr_ev  = en & a_e & b_e;
  assign idx_ev   = en & idx_in & ~idx_d;
  assign idx_load = idx_ev & idx_rst;
  assign nx       = next_pos(position, cnt_up, wrap_en, cfg_max, cfg_init);
  assign pos_n    = idx_load ? cfg_init : (step_ev ? nx[CW-1:0] : position);
  assign wrap_ev  = step_ev & ~idx_load & nx[CW];
  assign move_ev  = step_ev | idx_load;
  assign cmp_ev   = move_ev & (pos_n == cfg_cmp);
  assign dir_ev   = step_ev & (cnt_up != dir_up);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_d <= 1'b0; b_d <= 1'b0; idx_d <= 1'b0;
      position <= '0; index_cnt <= '0; dir_up <= 1'b1;
    end else begin
      a_d <= a; b_d <= b; idx_d <= idx_in;
      position <= pos_n;
      if (step_ev) dir_up <= cnt_up;
      if (idx_ev) index_cnt <= position;
    end
  end

  // R12
  qerr_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    qerr_ev |-> !step_ev);
  // R7
  wrap_up_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_ev && cnt_up) |=> position == $past(cfg_init));
  // R8
  idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_load |=> (position == $past(cfg_init) && index_cnt == $past(position)));
  // R14
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(position));
endmodule

// File: rtl/qenc_capture.sv
module qenc_capture #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic          cap_in,
  input  logic [CW-1:0] dly,
  input  logic [CW-1:0] pos,
  output logic [CW-1:0] capture,
  output logic          cap_ev
);
  logic cap_d, rise, pend;
  logic [CW-1:0] left;

  assign rise   = en & cap_in & ~cap_d;
  assign cap_ev = (rise && dly == '0) || (!rise && pend && tick && left == 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_d <= 1'b0; pend <= 1'b0; left <= '0; capture <= '0;
    end else begin
      cap_d <= cap_in;
      if (rise) begin
        pend <= (dly != '0);
        left <= dly;
      end else if (pend && tick) begin
        if (left == 1) pend <= 1'b0;
        else left <= left - 1'b1;
      end
      if (cap_ev) capture <= pos;
    end
  end

  // R9
  cap_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ev |=> capture == $past(pos));
endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
  import qenc_pkg::*;
#(
  parameter int CW  = 32,
  parameter int PSW = 3,
  parameter int FW  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic             enc_idx,
  input  logic             enc_cap,
  input  logic             cfg_en,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_swap,
  input  logic [FW-1:0]    cfg_filt,
  input  logic [PSW-1:0]   cfg_pre,
  input  logic             cfg_idx_rst,
  input  logic             cfg_wrap_en,
  input  logic             cfg_sticky,
  input  logic [CW-1:0]    cfg_max,
  input  logic [CW-1:0]    cfg_init,
  input  logic [CW-1:0]    cfg_cmp,
  input  logic [CW-1:0]    cfg_cap_dly,
  input  logic [NFLAG-1:0] irq_en,
  input  logic [NFLAG-1:0] flag_clr,
  output logic [CW-1:0]    position,
  output logic [CW-1:0]    index_cnt,
  output logic [CW-1:0]    capture_cnt,
  output logic             dir_up,
  output logic [NFLAG-1:0] flags,
  output logic             irq
);
  localparam int LANES = 4;

  logic tick;
  logic [LANES-1:0] lvl;
  logic idx_ev, qerr_ev, cmp_ev, wrap_ev, dir_ev, move_ev, cap_ev;
  logic [NFLAG-1:0] ev;

  qenc_tick #(.PSW(PSW)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(cfg_en), .pre(cfg_pre), .tick(tick));

  qenc_filter #(.LANES(LANES), .FW(FW)) u_filt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .len(cfg_filt),
    .raw({enc_cap, enc_idx, enc_b, enc_a}), .lvl(lvl));

  qenc_core #(.CW(CW)) u_core (
    .clk(clk), .rst_n(rst_n), .en(cfg_en), .a_in(lvl[0]), .b_in(lvl[1]),
    .idx_in(lvl[2]), .mode(cfg_mode), .swap(cfg_swap), .idx_rst(cfg_idx_rst),
    .wrap_en(cfg_wrap_en), .cfg_max(cfg_max), .cfg_init(cfg_init), .cfg_cmp(cfg_cmp),
    .position(position), .index_cnt(index_cnt), .dir_up(dir_up),
    .idx_ev(idx_ev), .qerr_ev(qerr_ev), .cmp_ev(cmp_ev), .wrap_ev(wrap_ev),
    .dir_ev(dir_ev), .move_ev(move_ev));

  qenc_capture #(.CW(CW)) u_cap (
    .clk(clk), .rst_n(rst_n), .en(cfg_en), .tick(tick), .cap_in(lvl[3]),
    .dly(cfg_cap_dly), .pos(position), .capture(capture_cnt), .cap_ev(cap_ev));

  always_comb begin
    ev = '0;
    ev[FB_IDX]  = idx_ev;
    ev[FB_ERR]  = qerr_ev;
    ev[FB_CMP]  = cmp_ev;
    ev[FB_WRAP] = wrap_ev;
    ev[FB_CAP]  = cap_ev;
    ev[FB_DIR]  = dir_ev;
    ev[FB_MOVE] = move_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else if (cfg_sticky) flags <= (flags & ~flag_clr) | ev;
    else flags <= ev;
  end

  assign irq = |(flags & irq_en);

  // R13
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sticky && flags[FB_MOVE] && !flag_clr[FB_MOVE]) |=> flags[FB_MOVE]);
  // R14
  no_flag_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !cfg_sticky) |=> flags == '0);
endmodule

// File: tb/qenc_counter_tb_top.sv
module qenc_counter_tb_top;
  localparam int CLK_PER = 10;

  typedef struct {
    int          kind;
    string       req;
    logic [31:0] exp;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enc_a = 0, enc_b = 0, enc_idx = 0, enc_cap = 0;
  logic cfg_en = 1, cfg_swap = 0, cfg_idx_rst = 0, cfg_wrap_en = 0, cfg_sticky = 1;
  logic [1:0] cfg_mode = 2'd2, cfg_filt = 2'd0;
  logic [2:0] cfg_pre = 3'd0;
  logic [31:0] cfg_max = 0, cfg_init = 0, cfg_cmp = 32'd1000, cfg_cap_dly = 0;
  logic [6:0] irq_en = 0, flag_clr = 0;
  logic [31:0] position, index_cnt, capture_cnt;
  logic dir_up, irq;
  logic [6:0] flags;

  item_t sb[$];
  int n_chk = 0, n_fail = 0;
  int ph = 0;
  logic [31:0] exp_pos = 0;
  bit done = 0;

  always #(CLK_PER/2) clk = ~clk;

  qenc_counter dut_i (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
    .enc_cap(enc_cap), .cfg_en(cfg_en), .cfg_mode(cfg_mode), .cfg_swap(cfg_swap),
    .cfg_filt(cfg_filt), .cfg_pre(cfg_pre), .cfg_idx_rst(cfg_idx_rst),
    .cfg_wrap_en(cfg_wrap_en), .cfg_sticky(cfg_sticky), .cfg_max(cfg_max),
    .cfg_init(cfg_init), .cfg_cmp(cfg_cmp), .cfg_cap_dly(cfg_cap_dly),
    .irq_en(irq_en), .flag_clr(flag_clr), .position(position), .index_cnt(index_cnt),
    .capture_cnt(capture_cnt), .dir_up(dir_up), .flags(flags), .irq(irq));

  // phase table as {a,b}
  function automatic logic [1:0] ph_ab(int p);
    case (p)
      0: return 2'b00;
      1: return 2'b10;
      2: return 2'b11;
      default: return 2'b01;
    endcase
  endfunction

  function automatic int delta(int mode, bit fwd, logic [1:0] o, logic [1:0] n);
    if (mode >= 2) return fwd ? 1 : -1;
    if (mode == 1) return (o[1] != n[1]) ? (fwd ? 1 : -1) : 0;
    if (!o[1] && n[1]) return n[0] ? -1 : 1;
    return 0;
  endfunction

  function automatic logic [31:0] model_move(logic [31:0] p, bit up);
    if (up) return (cfg_wrap_en && p == cfg_max) ? cfg_init : p + 1;
    return (cfg_wrap_en && p == cfg_init) ? cfg_max : p - 1;
  endfunction

  function automatic int settle();
    return 6 + (1 << cfg_pre) * (int'(cfg_filt) + 2);
  endfunction

  task automatic chk(int kind, string req, logic [31:0] exp);
    item_t it;
    it.kind = kind; it.req = req; it.exp = exp;
    sb.push_back(it);
    @(negedge clk);
  endtask

  task automatic step(bit fwd);
    logic [1:0] o, n;
    int d;
    o = ph_ab(ph);
    ph = fwd ? (ph + 1) % 4 : (ph + 3) % 4;
    n = ph_ab(ph);
    @(negedge clk);
    enc_a = n[1]; enc_b = n[0];
    repeat (settle()) @(negedge clk);
    if (cfg_en) begin
      d = delta(int'(cfg_mode), fwd, o, n);
      if (cfg_swap) d = -d;
      if (d > 0) exp_pos = model_move(exp_pos, 1'b1);
      else if (d < 0) exp_pos = model_move(exp_pos, 1'b0);
    end
  endtask

  task automatic clr_all();
    @(negedge clk); flag_clr = 7'h7F;
    @(negedge clk); flag_clr = 7'h00;
  endtask

  // monitor: pops expectations and compares against the ports
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        case (it.kind)
          0: act = position;
          1: act = {25'd0, flags};
          2: act = index_cnt;
          3: act = capture_cnt;
          4: act = {31'd0, dir_up};
          default: act = {31'd0, irq};
        endcase
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] old_pos;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(0, "R1", 0); chk(1, "R1", 0); chk(2, "R1", 0); chk(3, "R1", 0);
    chk(4, "R1", 1); chk(5, "R1", 0);

    // R2 x4 forward and reverse, R11 flags and direction
    for (int i = 0; i < 4; i++) step(1);
    chk(0, "R2", exp_pos); chk(1, "R11", 32'h40); chk(4, "R11", 1);
    clr_all();
    for (int i = 0; i < 4; i++) step(0);
    chk(0, "R2", exp_pos); chk(1, "R11", 32'h60); chk(4, "R11", 0);
    clr_all();

    // R3 x2 and x1
    cfg_mode = 2'd1;
    for (int i = 0; i < 4; i++) step(1);
    chk(0, "R3", exp_pos);
    cfg_mode = 2'd0;
    for (int i = 0; i < 4; i++) step(1);
    chk(0, "R3", exp_pos);
    for (int i = 0; i < 4; i++) step(0);
    chk(0, "R3", exp_pos);

    // R4 swap
    cfg_mode = 2'd2; cfg_swap = 1;
    for (int i = 0; i < 4; i++) step(1);
    chk(0, "R4", exp_pos); chk(4, "R4", 0);
    cfg_swap = 0;
    clr_all();

    // R12 illegal transition
    @(negedge clk); enc_a = 1; enc_b = 1;
    repeat (settle()) @(negedge clk);
    chk(0, "R12", exp_pos); chk(1, "R12", 32'h02);
    @(negedge clk); enc_a = 0; enc_b = 0;
    repeat (settle()) @(negedge clk);
    clr_all();

    // R5 filter: a 3-sample glitch with 4-sample filter is rejected
    cfg_filt = 2'd3;
    @(negedge clk); enc_a = 1;
    repeat (3) @(negedge clk);
    enc_a = 0;
    repeat (settle()) @(negedge clk);
    chk(0, "R5", exp_pos); chk(1, "R5", 0);
    step(1);
    chk(0, "R5", exp_pos);

    // R6 prescaler: 8-cycle glitch sees one tick, 2-sample filter rejects it
    cfg_pre = 3'd3; cfg_filt = 2'd1;
    @(negedge clk); enc_b = 1;
    repeat (8) @(negedge clk);
    enc_b = 0;
    repeat (settle()) @(negedge clk);
    chk(0, "R6", exp_pos);
    step(0);
    chk(0, "R6", exp_pos);
    cfg_pre = 3'd0; cfg_filt = 2'd0;
    clr_all();

    // R8 index latch and reload
    cfg_wrap_en = 1; cfg_init = 32'd10; cfg_max = 32'd13; cfg_idx_rst = 1;
    old_pos = exp_pos;
    @(negedge clk); enc_idx = 1;
    repeat (4) @(negedge clk);
    enc_idx = 0;
    repeat (6) @(negedge clk);
    exp_pos = 32'd10;
    chk(0, "R8", 32'd10); chk(2, "R8", old_pos); chk(1, "R8", 32'h41);

    // R7 wrap both ways
    for (int i = 0; i < 3; i++) step(1);
    chk(0, "R7", 32'd13);
    clr_all();
    step(1);
    chk(0, "R7", 32'd10); chk(1, "R7", 32'h48);
    clr_all();
    step(0);
    chk(0, "R7", 32'd13); chk(1, "R7", 32'h68);
    clr_all();

    // R10 compare
    cfg_cmp = 32'd12;
    for (int i = 0; i < 3; i++) step(1);
    chk(0, "R10", 32'd12); chk(1, "R10", 32'h6C);
    clr_all();

    // R9 delayed capture
    cfg_cap_dly = 32'd5;
    @(negedge clk); enc_cap = 1;
    repeat (2) @(negedge clk);
    enc_cap = 0;
    repeat (3) @(negedge clk);
    chk(3, "R9", 32'd0);
    repeat (5) @(negedge clk);
    chk(3, "R9", 32'd12); chk(1, "R9", 32'h10);
    clr_all();

    // R13 non-sticky, then masking of irq
    cfg_sticky = 0;
    step(1);
    chk(0, "R13", exp_pos); chk(1, "R13", 0);
    cfg_sticky = 1;
    clr_all();
    irq_en = 7'h40;
    step(0);
    chk(1, "R13", 32'h64); chk(5, "R13", 1);
    irq_en = 7'h01;
    chk(5, "R13", 0);
    irq_en = 7'h04;
    chk(5, "R13", 1);
    clr_all();
    chk(1, "R13", 0); chk(5, "R13", 0);

    // R14 disabled: stepping has no effect
    cfg_en = 0;
    for (int i = 0; i < 4; i++) step(1);
    chk(0, "R14", exp_pos); chk(1, "R14", 0);
    cfg_en = 1;
    repeat (settle()) @(negedge clk);
    chk(0, "R14", 32'd12); chk(1, "R14", 0);

    wait (sb.size() == 0);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule